// File: doc/BRIEF.md
# Task Register Load/Store Unit

This block holds the identity of the running task. A 16-bit selector is the part software can see. Behind it sits a cached copy of the task-state descriptor that software cannot read: a 32-bit base, a 16-bit limit and 16 attribute bits. Three things can change or read the register:

- An explicit load request first checks the caller's privilege and the selector. It then fetches the 64-bit descriptor over a valid/ready request port and a separate response strobe. It checks the descriptor and, if every check passes, fills both parts of the register. It also asks for the descriptor to be written back to memory marked busy.
- A store request returns only the visible selector.
- The task-switch sequencer can overwrite every field at once through an update port.

A rejected load reports a two-bit fault code together with the selector that caused it. A rejected load leaves the register untouched. Only one explicit load is in flight at a time.

Top module: `task_reg_unit`

## Requirements
- R1: After reset the selector reads 0, `tr_valid_o` is 0, `fault_o` is 0, and no descriptor read, write-back or completion is signalled.
- R2: A load request taken while `cpl_i` is not 0 raises fault code 1 (general protection) with the request's selector in the following cycle. No descriptor read is issued and the register is unchanged.
- R3: A load request at privilege 0 whose selector has bit 2 set (local-table indicator) raises fault code 1 in the following cycle. No descriptor read is issued.
- R4: An accepted load drives `dr_valid_o` with `dr_index_o` equal to selector bits 15:3. Both hold steady until `dr_ready_i` is seen. The unit then waits for `dr_rsp_valid_i`. Load requests arriving before the load completes are ignored.
- R5: The response bits are decoded as follows: limit = d[15:0]; base = {d[63:56], d[39:16]}; attributes = d[55:40]; present = d[47]. The 5-bit system/type field d[44:40] must equal 01001 (available task), or fault code 1 is raised.
- R6: With the type correct, present = 0 raises fault code 2 (invalid task). A limit below 0x67 also raises fault code 2. A limit of exactly 0x67 is accepted.
- R7: A load that passes every check loads the selector, base, limit and attributes, with the attribute type bits (3:0) set to 1011. It sets `tr_valid_o`. In the cycle after the response it pulses `ld_done_o` and `wb_valid_o`, with `wb_index_o` set to the descriptor index and `wb_type_o` = 1011.
- R8: The fault code is 0 (none), 1 or 2, never 3. Each fault is reported for exactly one cycle. A fault and `ld_done_o` never occur in the same cycle.
- R9: A store request is served at any privilege level. In the following cycle `st_valid_o` is 1 and `st_sel_o` holds the visible selector.
- R10: An update from the task-switch port writes the selector, base, limit and attributes, and sets `tr_valid_o`, all visible in the next cycle. If it arrives on the same edge as a load response, the update wins. That load then produces no completion, no write-back and no fault.
- R11: A rejected load leaves the selector and the cached descriptor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpl_i | input | 2 | Privilege level of the requester |
| ld_valid_i | input | 1 | Explicit load request |
| ld_sel_i | input | 16 | Selector to load |
| st_valid_i | input | 1 | Store request |
| st_valid_o | output | 1 | Store result valid |
| st_sel_o | output | 16 | Visible selector returned by a store |
| sw_valid_i | input | 1 | Task-switch update strobe |
| sw_sel_i | input | 16 | Update selector |
| sw_base_i | input | 32 | Update base |
| sw_limit_i | input | 16 | Update limit |
| sw_attr_i | input | 16 | Update attributes |
| dr_valid_o | output | 1 | Descriptor read request |
| dr_ready_i | input | 1 | Descriptor read accepted |
| dr_index_o | output | 13 | Descriptor index requested |
| dr_rsp_valid_i | input | 1 | Descriptor response strobe |
| dr_rsp_data_i | input | 64 | Descriptor response bits |
| wb_valid_o | output | 1 | Busy write-back request |
| wb_index_o | output | 13 | Index of descriptor to mark busy |
| wb_type_o | output | 4 | Type value to write back |
| ld_done_o | output | 1 | Explicit load completed |
| fault_o | output | 2 | Fault code: 0 none, 1 general protection, 2 invalid task |
| fault_sel_o | output | 16 | Selector that caused the fault |
| tr_sel_o | output | 16 | Current visible selector |
| tr_base_o | output | 32 | Cached base |
| tr_limit_o | output | 16 | Cached limit |
| tr_attr_o | output | 16 | Cached attributes |
| tr_valid_o | output | 1 | Cached descriptor valid |

## Verification
The assertions check several properties on every cycle:
- the descriptor request holds steady until it is accepted;
- a low-privilege request issues no read and faults at once;
- the fault code stays legal, and a fault never coincides with completion;
- a completion always finds the register valid and marked busy;
- the selector holds whenever no write strobe was present.

The following can only be shown by the bench's directed scenarios:
- the exact decoding of base, limit and attributes from the response bits;
- the choice between fault codes for type, presence and the 0x67 limit boundary;
- that requests are ignored while a load is in flight;
- that the switch update wins a same-edge collision.

// File: rtl/tr_pkg.sv
package tr_pkg;
  parameter int unsigned SEL_W  = 16;
  parameter int unsigned BASE_W = 32;
  parameter int unsigned LIM_W  = 16;
  parameter int unsigned ATTR_W = 16;
  parameter int unsigned DESC_W = 64;
  parameter int unsigned CPL_W  = 2;
  localparam int unsigned IDX_W = SEL_W - 3;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_TS   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [ATTR_W-1:0] attr;
  } tr_cache_t;
endpackage

// File: rtl/tr_desc_decode.sv
module tr_desc_decode
  import tr_pkg::*;
#(
  parameter logic [LIM_W-1:0] MIN_LIMIT = 16'h0067
) (
  input  logic [DESC_W-1:0] desc_i,
  output tr_cache_t         cache_o,
  output logic              type_ok_o,
  output logic              present_o,
  output logic              limit_ok_o
);
  localparam logic [4:0] TYPE_AVAIL = 5'b01001;

  logic [LIM_W-1:0] limit;

  assign limit      = desc_i[15:0];
  assign type_ok_o  = (desc_i[44:40] == TYPE_AVAIL);
  assign present_o  = desc_i[47];
  assign limit_ok_o = (limit >= MIN_LIMIT);

  // cached copy already carries the busy mark
  assign cache_o.base  = {desc_i[63:56], desc_i[39:16]};
  assign cache_o.limit = limit;
  assign cache_o.attr  = {desc_i[55:42], 1'b1, desc_i[40]};
endmodule

// File: rtl/tr_state_regs.sv
module tr_state_regs
  import tr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [SEL_W-1:0] sw_sel_i,
  input  tr_cache_t        sw_cache_i,
  input  logic             ld_we_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  tr_cache_t        ld_cache_i,
  input  logic             st_req_i,
  output logic [SEL_W-1:0] sel_o,
  output tr_cache_t        cache_o,
  output logic             valid_o,
  output logic             st_valid_o,
  output logic [SEL_W-1:0] st_sel_o
);
  logic [SEL_W-1:0] sel_q;
  tr_cache_t        cache_q;
  logic             valid_q;
  logic             past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      cache_q <= '0;
      valid_q <= 1'b0;
    end else if (sw_we_i) begin
      sel_q   <= sw_sel_i;
      cache_q <= sw_cache_i;
      valid_q <= 1'b1;
    end else if (ld_we_i) begin
      sel_q   <= ld_sel_i;
      cache_q <= ld_cache_i;
      valid_q <= 1'b1;
    end
  end

  // store path sees only the visible selector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_valid_o <= 1'b0;
      st_sel_o   <= '0;
      past_ok_q  <= 1'b0;
    end else begin
      st_valid_o <= st_req_i;
      st_sel_o   <= st_req_i ? sel_q : '0;
      past_ok_q  <= 1'b1;
    end
  end

  assign sel_o   = sel_q;
  assign cache_o = cache_q;
  assign valid_o = valid_q;

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(sw_we_i) && !$past(ld_we_i) |-> $stable(sel_q) && $stable(cache_q)); // R11
endmodule

// File: rtl/tr_ld_ctrl.sv
module tr_ld_ctrl
  import tr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CPL_W-1:0] cpl_i,
  input  logic             ld_valid_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  logic             sw_valid_i,
  input  logic             dr_ready_i,
  input  logic             dr_rsp_valid_i,
  input  logic             type_ok_i,
  input  logic             present_i,
  input  logic             limit_ok_i,
  input  logic [3:0]       busy_type_i,
  output logic             dr_valid_o,
  output logic [IDX_W-1:0] dr_index_o,
  output logic             ld_we_o,
  output logic [SEL_W-1:0] ld_sel_o,
  output logic             wb_valid_o,
  output logic [IDX_W-1:0] wb_index_o,
  output logic [3:0]       wb_type_o,
  output logic             done_o,
  output logic [1:0]       fault_o,
  output logic [SEL_W-1:0] fault_sel_o
);
  state_e           state_q, state_d;
  logic [SEL_W-1:0] pend_q;
  logic             rsp_take;
  logic             chk_ok;
  fault_e           flt_d;
  logic [SEL_W-1:0] flt_sel_d;

  assign rsp_take = (state_q == ST_WAIT) && dr_rsp_valid_i;
  assign chk_ok   = type_ok_i && present_i && limit_ok_i;
  assign ld_we_o  = rsp_take && !sw_valid_i && chk_ok;

  always_comb begin
    state_d   = state_q;
    flt_d     = FLT_NONE;
    flt_sel_d = '0;
    unique case (state_q)
      ST_IDLE: if (ld_valid_i) begin
        if (cpl_i != '0) begin
          flt_d     = FLT_GP;
          flt_sel_d = ld_sel_i;
        end else if (ld_sel_i[2]) begin
          flt_d     = FLT_GP;
          flt_sel_d = ld_sel_i;
        end else begin
          state_d = ST_REQ;
        end
      end
      ST_REQ: if (dr_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (dr_rsp_valid_i) begin
        state_d = ST_IDLE;
        if (!sw_valid_i) begin
          if (!type_ok_i) begin
            flt_d     = FLT_GP;
            flt_sel_d = pend_q;
          end else if (!present_i || !limit_ok_i) begin
            flt_d     = FLT_TS;
            flt_sel_d = pend_q;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_q      <= '0;
      fault_o     <= FLT_NONE;
      fault_sel_o <= '0;
      wb_valid_o  <= 1'b0;
      wb_index_o  <= '0;
      wb_type_o   <= '0;
      done_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      fault_o     <= flt_d;
      fault_sel_o <= flt_sel_d;
      done_o      <= ld_we_o;
      wb_valid_o  <= ld_we_o;
      wb_index_o  <= ld_we_o ? pend_q[SEL_W-1:3] : '0;
      wb_type_o   <= ld_we_o ? busy_type_i : '0;
      if (state_q == ST_IDLE && state_d == ST_REQ) pend_q <= ld_sel_i;
    end
  end

  assign dr_valid_o = (state_q == ST_REQ);
  assign dr_index_o = pend_q[SEL_W-1:3];
  assign ld_sel_o   = pend_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_valid_o && !dr_ready_i |=> dr_valid_o && $stable(dr_index_o)); // R4
  AST_LOW_CPL_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && ld_valid_i && (cpl_i != '0) |=> !dr_valid_o && (fault_o == FLT_GP)); // R2
  AST_FAULT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o != 2'b11); // R8
endmodule

// File: rtl/task_reg_unit.sv
module task_reg_unit
  import tr_pkg::*;
#(
  parameter logic [15:0] MIN_LIMIT = 16'h0067
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPL_W-1:0]  cpl_i,
  input  logic              ld_valid_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic              st_valid_i,
  output logic              st_valid_o,
  output logic [SEL_W-1:0]  st_sel_o,
  input  logic              sw_valid_i,
  input  logic [SEL_W-1:0]  sw_sel_i,
  input  logic [BASE_W-1:0] sw_base_i,
  input  logic [LIM_W-1:0]  sw_limit_i,
  input  logic [ATTR_W-1:0] sw_attr_i,
  output logic              dr_valid_o,
  input  logic              dr_ready_i,
  output logic [IDX_W-1:0]  dr_index_o,
  input  logic              dr_rsp_valid_i,
  input  logic [DESC_W-1:0] dr_rsp_data_i,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_index_o,
  output logic [3:0]        wb_type_o,
  output logic              ld_done_o,
  output logic [1:0]        fault_o,
  output logic [SEL_W-1:0]  fault_sel_o,
  output logic [SEL_W-1:0]  tr_sel_o,
  output logic [BASE_W-1:0] tr_base_o,
  output logic [LIM_W-1:0]  tr_limit_o,
  output logic [ATTR_W-1:0] tr_attr_o,
  output logic              tr_valid_o
);
  tr_cache_t        dec_cache;
  tr_cache_t        sw_cache;
  tr_cache_t        cur_cache;
  logic             type_ok, present, limit_ok;
  logic             ld_we;
  logic [SEL_W-1:0] ld_sel;

  assign sw_cache.base  = sw_base_i;
  assign sw_cache.limit = sw_limit_i;
  assign sw_cache.attr  = sw_attr_i;

  tr_desc_decode #(.MIN_LIMIT(MIN_LIMIT)) u_dec (
    .desc_i     (dr_rsp_data_i),
    .cache_o    (dec_cache),
    .type_ok_o  (type_ok),
    .present_o  (present),
    .limit_ok_o (limit_ok)
  );

  tr_ld_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cpl_i          (cpl_i),
    .ld_valid_i     (ld_valid_i),
    .ld_sel_i       (ld_sel_i),
    .sw_valid_i     (sw_valid_i),
    .dr_ready_i     (dr_ready_i),
    .dr_rsp_valid_i (dr_rsp_valid_i),
    .type_ok_i      (type_ok),
    .present_i      (present),
    .limit_ok_i     (limit_ok),
    .busy_type_i    (dec_cache.attr[3:0]),
    .dr_valid_o     (dr_valid_o),
    .dr_index_o     (dr_index_o),
    .ld_we_o        (ld_we),
    .ld_sel_o       (ld_sel),
    .wb_valid_o     (wb_valid_o),
    .wb_index_o     (wb_index_o),
    .wb_type_o      (wb_type_o),
    .done_o         (ld_done_o),
    .fault_o        (fault_o),
    .fault_sel_o    (fault_sel_o)
  );

  tr_state_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (sw_valid_i),
    .sw_sel_i   (sw_sel_i),
    .sw_cache_i (sw_cache),
    .ld_we_i    (ld_we),
    .ld_sel_i   (ld_sel),
    .ld_cache_i (dec_cache),
    .st_req_i   (st_valid_i),
    .sel_o      (tr_sel_o),
    .cache_o    (cur_cache),
    .valid_o    (tr_valid_o),
    .st_valid_o (st_valid_o),
    .st_sel_o   (st_sel_o)
  );

  assign tr_base_o  = cur_cache.base;
  assign tr_limit_o = cur_cache.limit;
  assign tr_attr_o  = cur_cache.attr;

  AST_DONE_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_done_o |-> tr_valid_o && (tr_attr_o[3:0] == 4'b1011) && (tr_sel_o[SEL_W-1:3] == wb_index_o)); // R7
  AST_FAULT_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((fault_o != 2'b00) && ld_done_o)); // R8
endmodule

// File: tb/sim_task_reg_unit.sv
`timescale 1ns/1ps
module sim_task_reg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpl = '0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_sel = '0;
  logic        st_valid = 1'b0;
  logic        sw_valid = 1'b0;
  logic [15:0] sw_sel = '0;
  logic [31:0] sw_base = '0;
  logic [15:0] sw_limit = '0;
  logic [15:0] sw_attr = '0;
  logic        dr_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;

  logic        st_valid_o, dr_valid_o, wb_valid_o, ld_done_o, tr_valid_o;
  logic [15:0] st_sel_o, fault_sel_o, tr_sel_o, tr_limit_o, tr_attr_o;
  logic [12:0] dr_index_o, wb_index_o;
  logic [3:0]  wb_type_o;
  logic [1:0]  fault_o;
  logic [31:0] tr_base_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  task_reg_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpl_i(cpl),
    .ld_valid_i(ld_valid), .ld_sel_i(ld_sel),
    .st_valid_i(st_valid), .st_valid_o(st_valid_o), .st_sel_o(st_sel_o),
    .sw_valid_i(sw_valid), .sw_sel_i(sw_sel), .sw_base_i(sw_base),
    .sw_limit_i(sw_limit), .sw_attr_i(sw_attr),
    .dr_valid_o(dr_valid_o), .dr_ready_i(dr_ready), .dr_index_o(dr_index_o),
    .dr_rsp_valid_i(rsp_valid), .dr_rsp_data_i(rsp_data),
    .wb_valid_o(wb_valid_o), .wb_index_o(wb_index_o), .wb_type_o(wb_type_o),
    .ld_done_o(ld_done_o), .fault_o(fault_o), .fault_sel_o(fault_sel_o),
    .tr_sel_o(tr_sel_o), .tr_base_o(tr_base_o), .tr_limit_o(tr_limit_o),
    .tr_attr_o(tr_attr_o), .tr_valid_o(tr_valid_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [15:0] lim,
                                          input logic [4:0] typ, input logic p);
    logic [63:0] d = '0;
    d[15:0]  = lim;
    d[39:16] = base[23:0];
    d[44:40] = typ;
    d[47]    = p;
    d[63:56] = base[31:24];
    return d;
  endfunction

  // request, hold-off, accept, respond; leaves the tb at the negedge after the response edge
  task automatic run_load(input logic [15:0] sel, input logic [63:0] desc,
                          input int delay, input logic inject_sw);
    cpl = 2'd0; ld_valid = 1'b1; ld_sel = sel;
    step();
    ld_valid = 1'b0;
    chk("R4", "dr_valid after accept", 64'(dr_valid_o), 64'd1);
    chk("R4", "dr_index", 64'(dr_index_o), 64'(sel[15:3]));
    for (int i = 0; i < delay; i++) begin
      if (i == 0) begin ld_valid = 1'b1; ld_sel = 16'h0100; end
      step();
      ld_valid = 1'b0;
      chk("R4", "dr_valid held", 64'(dr_valid_o), 64'd1);
      chk("R4", "dr_index held", 64'(dr_index_o), 64'(sel[15:3]));
      chk("R4", "no fault while busy", 64'(fault_o), 64'd0);
    end
    dr_ready = 1'b1;
    step();
    dr_ready = 1'b0;
    chk("R4", "dr_valid drops after ready", 64'(dr_valid_o), 64'd0);
    rsp_valid = 1'b1; rsp_data = desc;
    if (inject_sw) begin
      sw_valid = 1'b1; sw_sel = 16'h0048; sw_base = 32'hCAFE_0000;
      sw_limit = 16'h0200; sw_attr = 16'h008B;
    end
    step();
    rsp_valid = 1'b0; sw_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "selector", 64'(tr_sel_o), 64'd0);
    chk("R1", "valid", 64'(tr_valid_o), 64'd0);
    chk("R1", "fault", 64'(fault_o), 64'd0);
    chk("R1", "dr_valid", 64'(dr_valid_o), 64'd0);
    chk("R1", "wb/done", 64'({wb_valid_o, ld_done_o}), 64'd0);
  endtask

  task automatic t_low_cpl();
    cpl = 2'd3; ld_valid = 1'b1; ld_sel = 16'h0030;
    step();
    ld_valid = 1'b0;
    chk("R2", "fault code", 64'(fault_o), 64'd1);
    chk("R2", "fault selector", 64'(fault_sel_o), 64'h0030);
    chk("R2", "no read", 64'(dr_valid_o), 64'd0);
    step();
    chk("R8", "fault one cycle", 64'(fault_o), 64'd0);
    chk("R2", "selector unchanged", 64'(tr_sel_o), 64'd0);
    chk("R2", "still invalid", 64'(tr_valid_o), 64'd0);
  endtask

  task automatic t_local_table();
    cpl = 2'd0; ld_valid = 1'b1; ld_sel = 16'h002C;
    step();
    ld_valid = 1'b0;
    chk("R3", "fault code", 64'(fault_o), 64'd1);
    chk("R3", "fault selector", 64'(fault_sel_o), 64'h002C);
    chk("R3", "no read", 64'(dr_valid_o), 64'd0);
    step();
  endtask

  task automatic t_good_load();
    run_load(16'h0028, mk_desc(32'h1234_5678, 16'h0067, 5'b01001, 1'b1), 2, 1'b0);
    chk("R7", "done pulse", 64'(ld_done_o), 64'd1);
    chk("R7", "wb valid", 64'(wb_valid_o), 64'd1);
    chk("R7", "wb index", 64'(wb_index_o), 64'd5);
    chk("R7", "wb type", 64'(wb_type_o), 64'hB);
    chk("R6", "limit 0x67 accepted, no fault", 64'(fault_o), 64'd0);
    chk("R7", "selector", 64'(tr_sel_o), 64'h0028);
    chk("R5", "base", 64'(tr_base_o), 64'h1234_5678);
    chk("R5", "limit", 64'(tr_limit_o), 64'h0067);
    chk("R7", "attr busy", 64'(tr_attr_o), 64'h008B);
    chk("R7", "valid", 64'(tr_valid_o), 64'd1);
    step();
    chk("R7", "done one cycle", 64'(ld_done_o), 64'd0);
    chk("R4", "interfering request ignored", 64'(dr_valid_o), 64'd0);
  endtask

  task automatic t_bad_desc(input logic [63:0] d, input logic [1:0] code, input string req);
    run_load(16'h0060, d, 0, 1'b0);
    chk(req, "fault code", 64'(fault_o), 64'(code));
    chk(req, "fault selector", 64'(fault_sel_o), 64'h0060);
    chk(req, "no done", 64'({ld_done_o, wb_valid_o}), 64'd0);
    chk("R11", "selector kept", 64'(tr_sel_o), 64'h0028);
    chk("R11", "base kept", 64'(tr_base_o), 64'h1234_5678);
    step();
    chk("R8", "fault cleared", 64'(fault_o), 64'd0);
  endtask

  task automatic t_store();
    cpl = 2'd3; st_valid = 1'b1;
    step();
    st_valid = 1'b0;
    chk("R9", "store valid", 64'(st_valid_o), 64'd1);
    chk("R9", "store selector", 64'(st_sel_o), 64'(tr_sel_o));
    chk("R9", "store selector value", 64'(st_sel_o), 64'h0028);
    step();
  endtask

  task automatic t_switch();
    sw_valid = 1'b1; sw_sel = 16'h0070; sw_base = 32'h0BAD_F00D;
    sw_limit = 16'h1000; sw_attr = 16'h408B;
    step();
    sw_valid = 1'b0;
    chk("R10", "sel", 64'(tr_sel_o), 64'h0070);
    chk("R10", "base", 64'(tr_base_o), 64'h0BAD_F00D);
    chk("R10", "limit", 64'(tr_limit_o), 64'h1000);
    chk("R10", "attr", 64'(tr_attr_o), 64'h408B);
  endtask

  task automatic t_collision();
    run_load(16'h0028, mk_desc(32'h1234_5678, 16'h0067, 5'b01001, 1'b1), 1, 1'b1);
    chk("R10", "update wins sel", 64'(tr_sel_o), 64'h0048);
    chk("R10", "update wins base", 64'(tr_base_o), 64'hCAFE_0000);
    chk("R10", "no done/wb", 64'({ld_done_o, wb_valid_o}), 64'd0);
    chk("R10", "no fault", 64'(fault_o), 64'd0);
    step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_low_cpl();
    t_local_table();
    t_good_load();
    t_bad_desc(mk_desc(32'h0, 16'h0100, 5'b01011, 1'b1), 2'd1, "R5");
    t_bad_desc(mk_desc(32'h0, 16'h0100, 5'b11001, 1'b1), 2'd1, "R5");
    t_bad_desc(mk_desc(32'h0, 16'h0100, 5'b01001, 1'b0), 2'd2, "R6");
    t_bad_desc(mk_desc(32'h0, 16'h0066, 5'b01001, 1'b1), 2'd2, "R6");
    t_store();
    t_switch();
    t_collision();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule